// File: doc/BRIEF.md
# Descriptor-Driven Rectangle Blit Engine

This engine copies a rectangle of bytes from one window of external memory into another window of the same memory. A window is described by an entry in a descriptor table. The table fills one 256-byte page at a fixed address and holds sixteen entries of sixteen bytes each. An entry gives a byte base address, a line pitch counted in 256-byte pages, and a rectangle inside the window: a start column X, a start line Y, a width W and a height H. The engine reads both entries over its own memory port before it begins to move data.

The host starts a transfer with a single-cycle command that names a source entry, a destination entry and an operation. It does not wait for the result. It reads a status byte that shows busy, done and error. Two operations are supported. The plain copy writes every source byte. The masked copy treats a zero source byte as transparent, which lets a sprite be drawn over existing pixels. All traffic uses one byte-wide request/acknowledge port. Each read and each write is held until it is acknowledged, so the block works with memory of any latency.

Top module: `blit_engine`

## Requirements
- R1: While reset is asserted and after it is released with no command, the status byte is 0x00 and no memory request is raised.
- R2: An accepted command first reads 32 bytes: the 16 bytes of the source entry and then the 16 bytes of the destination entry, each in increasing address order, where entry n starts at table address + 16·n. Within an entry, multi-byte fields are little-endian, at these byte offsets: base 0–3, pitch in pages 6, X 7–8, Y 9–10, W 11–12, H 13–14. Bytes 4, 5 and 15 are read but have no effect.
- R3: Pixel (r, c) of a window is at base + (Y + r)·pitch·256 + X + c, computed modulo 2^ADDR_W.
- R4: The moved rectangle is min(srcW, dstW) bytes wide and min(srcH, dstH) lines tall. If either size is zero, the engine finishes after the descriptor reads and makes no pixel access.
- R5: Pixels are handled line by line from the top, and left to right within a line. Each pixel gets one read of the source. The write to the destination, when there is one, follows that read before the next pixel begins.
- R6: Operation 0 writes every pixel. Operation 1 writes no pixel whose source byte is 0x00. Operations 2 and 3 are rejected: they set the error bit and cause no memory access.
- R7: Status bit 0 is busy, bit 1 is done and bit 2 is error. Bits 7–3 read as zero. Busy and done are never set together. Done is set in the same cycle that busy falls at the end of a transfer. Accepting a command clears done and error.
- R8: A command that arrives while the engine is busy is dropped and sets the error bit. The transfer in progress finishes with the same memory result it would have had without that command.
- R9: A raised request keeps its address, direction and write data unchanged until the cycle in which acknowledge is high. Each acknowledge completes exactly one transfer, and read data is taken in that same cycle.

Clarification for R2: pitch is given in 256-byte pages, and X and W are given in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_src_id | input | 4 | Source descriptor index |
| cmd_dst_id | input | 4 | Destination descriptor index |
| cmd_op | input | 2 | Operation: 0 copy, 1 masked copy |
| status | output | 8 | {5'b0, error, done, busy} |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Transfer complete |
| mem_rdata | input | 8 | Read data, valid while mem_ack is high |

## Verification
The bench goes after these corner cases:
- **Unequal window sizes.** A design that takes the extent from only one descriptor writes past the smaller window, and the write count and memory image no longer match.
- **Zero-sized window.** A design that does not test for zero size before the first pixel wraps its counters and writes thousands of bytes.
- **Masked source bytes equal to zero.** A masked copy that ignores them overwrites pre-filled destination bytes.
- **Non-unit pitches and offsets.** A wrong address formula, or a wrong order of field bytes, sends reads and writes to addresses that differ from the per-pixel expected sequence.
- **Command during a running transfer.** A design that accepts it restarts the fetch and leaves a corrupted image.
- **Unsupported operation code.** A design that accepts it starts memory traffic and does not raise the error bit.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int DESC_BYTES  = 16;
  localparam int TABLE_BYTES = 256;
  localparam int ID_W        = $clog2(TABLE_BYTES / DESC_BYTES);
  localparam int OFF_W       = $clog2(DESC_BYTES);
  localparam int FIDX_W      = OFF_W + 1;
  localparam int COORD_W     = 16;
  localparam int BASE_W      = 32;

  localparam logic [1:0] OP_COPY   = 2'd0;
  localparam logic [1:0] OP_MASKED = 2'd1;

  typedef struct packed {
    logic [BASE_W-1:0]  base;
    logic [7:0]         pitch;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] w;
    logic [COORD_W-1:0] h;
  } win_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_READ,
    ST_WRITE
  } blit_state_t;

  function automatic logic op_known(input logic [1:0] op);
    return (op == OP_COPY) || (op == OP_MASKED);
  endfunction

  function automatic logic [COORD_W-1:0] min_coord(input logic [COORD_W-1:0] a,
                                                   input logic [COORD_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/blit_desc_store.sv
module blit_desc_store
  import blit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  output win_desc_t        src_desc,
  output win_desc_t        dst_desc
);

  win_desc_t view [2];

  for (genvar g = 0; g < 2; g++) begin : g_slot
    win_desc_t slot_q;
    win_desc_t slot_d;
    logic      slot_en;

    assign slot_en = wr_en && (wr_sel == 1'(g));

    always_comb begin
      slot_d = slot_q;
      case (wr_off)
        4'd0:  slot_d.base[7:0]   = wr_data;
        4'd1:  slot_d.base[15:8]  = wr_data;
        4'd2:  slot_d.base[23:16] = wr_data;
        4'd3:  slot_d.base[31:24] = wr_data;
        4'd6:  slot_d.pitch       = wr_data;
        4'd7:  slot_d.x[7:0]      = wr_data;
        4'd8:  slot_d.x[15:8]     = wr_data;
        4'd9:  slot_d.y[7:0]      = wr_data;
        4'd10: slot_d.y[15:8]     = wr_data;
        4'd11: slot_d.w[7:0]      = wr_data;
        4'd12: slot_d.w[15:8]     = wr_data;
        4'd13: slot_d.h[7:0]      = wr_data;
        4'd14: slot_d.h[15:8]     = wr_data;
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= slot_d;
      end
    end

    assign view[g] = slot_q;
  end

  assign src_desc = view[0];
  assign dst_desc = view[1];

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
  import blit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [BASE_W-1:0]  base,
  input  logic [7:0]         pitch,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] row,
  input  logic [COORD_W-1:0] col,
  output logic [ADDR_W-1:0]  addr
);

  logic [ADDR_W-1:0] line_idx;
  logic [ADDR_W-1:0] line_off;

  always_comb begin
    line_idx = ADDR_W'(y) + ADDR_W'(row);
    line_off = (line_idx * ADDR_W'(pitch)) << 8;
    addr     = ADDR_W'(base) + line_off + ADDR_W'(x) + ADDR_W'(col);
  end

endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] TABLE_ADDR = 'h0F00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [ID_W-1:0]    cmd_src_id,
  input  logic [ID_W-1:0]    cmd_dst_id,
  input  logic [1:0]         cmd_op,
  input  logic [COORD_W-1:0] src_w,
  input  logic [COORD_W-1:0] src_h,
  input  logic [COORD_W-1:0] dst_w,
  input  logic [COORD_W-1:0] dst_h,
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [ADDR_W-1:0]  dst_addr,
  input  logic               mem_ack,
  input  logic [7:0]         mem_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  output logic               desc_wr_en,
  output logic               desc_wr_sel,
  output logic [OFF_W-1:0]   desc_wr_off,
  output logic [7:0]         desc_wr_data,
  output logic [COORD_W-1:0] row,
  output logic [COORD_W-1:0] col,
  output logic               busy,
  output logic               done,
  output logic               err
);

  localparam logic [FIDX_W-1:0] FETCH_LAST = '1;

  blit_state_t        state_q, state_d;
  logic [FIDX_W-1:0]  fidx_q, fidx_d;
  logic [ID_W-1:0]    sid_q, sid_d, did_q, did_d;
  logic               masked_q, masked_d;
  logic [COORD_W-1:0] row_q, row_d, col_q, col_d;
  logic [COORD_W-1:0] w_q, w_d, h_q, h_d;
  logic [7:0]         data_q, data_d;
  logic               done_q, done_d, err_q, err_d;
  logic               step;
  logic [COORD_W-1:0] w_min, h_min;
  logic [ID_W-1:0]    fetch_id;
  logic [ADDR_W-1:0]  fetch_addr;

  assign w_min      = min_coord(src_w, dst_w);
  assign h_min      = min_coord(src_h, dst_h);
  assign fetch_id   = fidx_q[OFF_W] ? did_q : sid_q;
  assign fetch_addr = TABLE_ADDR + ADDR_W'({fetch_id, fidx_q[OFF_W-1:0]});

  always_comb begin
    state_d  = state_q;
    fidx_d   = fidx_q;
    sid_d    = sid_q;
    did_d    = did_q;
    masked_d = masked_q;
    row_d    = row_q;
    col_d    = col_q;
    w_d      = w_q;
    h_d      = h_q;
    data_d   = data_q;
    done_d   = done_q;
    err_d    = err_q;
    step     = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = fetch_addr;
    desc_wr_en = 1'b0;

    if (cmd_valid) begin
      if ((state_q == ST_IDLE) && op_known(cmd_op)) begin
        state_d  = ST_FETCH;
        fidx_d   = '0;
        sid_d    = cmd_src_id;
        did_d    = cmd_dst_id;
        masked_d = (cmd_op == OP_MASKED);
        done_d   = 1'b0;
        err_d    = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end

    case (state_q)
      ST_FETCH: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          desc_wr_en = 1'b1;
          if (fidx_q == FETCH_LAST) state_d = ST_SETUP;
          else                      fidx_d  = fidx_q + FIDX_W'(1);
        end
      end
      ST_SETUP: begin
        w_d   = w_min;
        h_d   = h_min;
        row_d = '0;
        col_d = '0;
        if ((w_min == '0) || (h_min == '0)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        mem_req  = 1'b1;
        mem_addr = src_addr;
        if (mem_ack) begin
          data_d = mem_rdata;
          if (masked_q && (mem_rdata == 8'h00)) step    = 1'b1;
          else                                  state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_addr;
        if (mem_ack) step = 1'b1;
      end
      default: ;
    endcase

    if (step) begin
      state_d = ST_READ;
      if ((col_q + COORD_W'(1)) == w_q) begin
        col_d = '0;
        if ((row_q + COORD_W'(1)) == h_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          row_d = row_q + COORD_W'(1);
        end
      end else begin
        col_d = col_q + COORD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fidx_q   <= '0;
      sid_q    <= '0;
      did_q    <= '0;
      masked_q <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      w_q      <= '0;
      h_q      <= '0;
      data_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      fidx_q   <= fidx_d;
      sid_q    <= sid_d;
      did_q    <= did_d;
      masked_q <= masked_d;
      row_q    <= row_d;
      col_q    <= col_d;
      w_q      <= w_d;
      h_q      <= h_d;
      data_q   <= data_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign mem_wdata    = data_q;
  assign desc_wr_sel  = fidx_q[OFF_W];
  assign desc_wr_off  = fidx_q[OFF_W-1:0];
  assign desc_wr_data = mem_rdata;
  assign row          = row_q;
  assign col          = col_q;
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign err          = err_q;

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] TABLE_ADDR = 'h0F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ID_W-1:0]   cmd_src_id,
  input  logic [ID_W-1:0]   cmd_dst_id,
  input  logic [1:0]        cmd_op,
  output logic [7:0]        status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata
);

  logic [1:0]         rst_pipe;
  logic               rst_core_n;
  win_desc_t          src_desc, dst_desc;
  logic               desc_wr_en, desc_wr_sel;
  logic [OFF_W-1:0]   desc_wr_off;
  logic [7:0]         desc_wr_data;
  logic [COORD_W-1:0] row, col;
  logic [ADDR_W-1:0]  src_addr, dst_addr;
  logic               busy, done, err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  blit_desc_store u_store (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (desc_wr_en),
    .wr_sel   (desc_wr_sel),
    .wr_off   (desc_wr_off),
    .wr_data  (desc_wr_data),
    .src_desc (src_desc),
    .dst_desc (dst_desc)
  );

  blit_addr_gen #(.ADDR_W(ADDR_W)) u_src_addr (
    .base  (src_desc.base),
    .pitch (src_desc.pitch),
    .x     (src_desc.x),
    .y     (src_desc.y),
    .row   (row),
    .col   (col),
    .addr  (src_addr)
  );

  blit_addr_gen #(.ADDR_W(ADDR_W)) u_dst_addr (
    .base  (dst_desc.base),
    .pitch (dst_desc.pitch),
    .x     (dst_desc.x),
    .y     (dst_desc.y),
    .row   (row),
    .col   (col),
    .addr  (dst_addr)
  );

  blit_ctrl #(.ADDR_W(ADDR_W), .TABLE_ADDR(TABLE_ADDR)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cmd_valid    (cmd_valid),
    .cmd_src_id   (cmd_src_id),
    .cmd_dst_id   (cmd_dst_id),
    .cmd_op       (cmd_op),
    .src_w        (src_desc.w),
    .src_h        (src_desc.h),
    .dst_w        (dst_desc.w),
    .dst_h        (dst_desc.h),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .desc_wr_en   (desc_wr_en),
    .desc_wr_sel  (desc_wr_sel),
    .desc_wr_off  (desc_wr_off),
    .desc_wr_data (desc_wr_data),
    .row          (row),
    .col          (col),
    .busy         (busy),
    .done         (done),
    .err          (err)
  );

  assign status = {5'b00000, err, done, busy};

endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        status,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ack
);

  // R9: an outstanding request is frozen until acknowledged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R1: no memory traffic while not busy
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> !mem_req);

  // R7: busy and done exclusive, spare bits zero
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[1]));

  assert_spare_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:3] == 5'b00000);

  // R7: done appears only as busy drops
  assert_done_with_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $fell(status[0]));

  // R8: a command while busy raises the error bit
  assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && cmd_valid) |=> status[2]);

endmodule

bind blit_engine blit_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .status    (status),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/sim_blit_engine.sv
module sim_blit_engine;

  localparam int          CLK_PERIOD = 10;
  localparam bit [31:0]   TBL        = 32'h0000_0F00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_src_id, cmd_dst_id;
  logic [1:0]  cmd_op;
  logic [7:0]  status;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;

  bit [7:0]  mem [bit [31:0]];
  bit [31:0] rlog[$];
  bit [31:0] wlog[$];
  int        wait_cnt = 0;

  bit [31:0] d_base [16];
  int        d_pitch [16], d_x [16], d_y [16], d_w [16], d_h [16];

  bit [7:0]  exp_m [bit [31:0]];
  bit [31:0] ewr[$];
  int        exp_s, exp_d, exp_w, exp_h;

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_engine #(.ADDR_W(32), .TABLE_ADDR(TBL)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src_id(cmd_src_id),
    .cmd_dst_id(cmd_dst_id), .cmd_op(cmd_op), .status(status), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic bit [7:0] mget(input bit [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic bit [31:0] px_addr(input int id, input int r, input int c);
    return d_base[id] + 32'((d_y[id] + r) * d_pitch[id] * 256 + d_x[id] + c);
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // memory model: acknowledge after 0..2 idle negedges, one cycle wide
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wlog.push_back(mem_addr);
        end else begin
          mem_rdata <= mget(mem_addr);
          rlog.push_back(mem_addr);
        end
        wait_cnt = $urandom_range(0, 2);
      end else begin
        wait_cnt = wait_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic set_desc(input int id, input bit [31:0] base, input int pitch,
                          input int x, input int y, input int w, input int h);
    bit [31:0] a = TBL + 32'(id * 16);
    mem[a+0]  = base[7:0];   mem[a+1]  = base[15:8];
    mem[a+2]  = base[23:16]; mem[a+3]  = base[31:24];
    mem[a+4]  = 8'hC4;       mem[a+5]  = 8'h3C;  // no effect (R2)
    mem[a+6]  = 8'(pitch);
    mem[a+7]  = 8'(x);       mem[a+8]  = 8'(x >> 8);
    mem[a+9]  = 8'(y);       mem[a+10] = 8'(y >> 8);
    mem[a+11] = 8'(w);       mem[a+12] = 8'(w >> 8);
    mem[a+13] = 8'(h);       mem[a+14] = 8'(h >> 8);
    mem[a+15] = 8'hEE;
    d_base[id] = base; d_pitch[id] = pitch; d_x[id] = x; d_y[id] = y;
    d_w[id] = w; d_h[id] = h;
  endtask

  task automatic issue(input int s, input int d, input int op);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_src_id = 4'(s);
    cmd_dst_id = 4'(d);
    cmd_op     = 2'(op);
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic start_blit(input int s, input int d, input int op);
    bit [7:0] v;
    exp_s = s; exp_d = d;
    exp_w = imin(d_w[s], d_w[d]);
    exp_h = imin(d_h[s], d_h[d]);
    exp_m = mem;
    ewr.delete();
    for (int r = 0; r < exp_h; r++) begin
      for (int c = 0; c < exp_w; c++) begin
        v = mget(px_addr(s, r, c));
        if (!(op == 1 && v == 8'h00)) begin
          exp_m[px_addr(d, r, c)] = v;
          ewr.push_back(px_addr(d, r, c));
        end
      end
    end
    rlog.delete();
    wlog.delete();
    issue(s, d, op);
  endtask

  task automatic finish_blit(input string tag);
    int cyc = 0;
    int bad;
    while (status[1] == 1'b0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(status[1] && !status[0], "R7", {tag, " done without busy"}, int'(status), 2);
    bad = 0;
    foreach (exp_m[k]) if (mget(k) != exp_m[k]) bad++;
    chk(bad == 0, "R6", {tag, " memory image mismatches"}, bad, 0);
    chk(wlog.size() == ewr.size(), "R4", {tag, " write count"}, wlog.size(), ewr.size());
    chk(rlog.size() == 32 + exp_w * exp_h, "R5", {tag, " read count"},
        rlog.size(), 32 + exp_w * exp_h);
    bad = 0;
    for (int k = 0; k < 32; k++)
      if (k >= rlog.size() || rlog[k] != TBL + 32'(((k < 16) ? exp_s : exp_d) * 16 + k % 16))
        bad++;
    chk(bad == 0, "R2", {tag, " descriptor fetch address mismatches"}, bad, 0);
    bad = 0;
    for (int i = 0; i < exp_w * exp_h; i++)
      if (32 + i >= rlog.size() || rlog[32+i] != px_addr(exp_s, i / exp_w, i % exp_w)) bad++;
    for (int i = 0; i < ewr.size(); i++)
      if (i >= wlog.size() || wlog[i] != ewr[i]) bad++;
    chk(bad == 0, "R3", {tag, " pixel address/order mismatches"}, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240509));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_src_id = '0; cmd_dst_id = '0; cmd_op = '0;
    mem_rdata = '0;

    for (int i = 0; i < 'h3000; i++) begin
      mem[32'h1_0000 + i] = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(1, 255));
      mem[32'h4_0000 + i] = 8'hA5;
    end

    repeat (3) @(negedge clk);
    chk(status == 8'h00 && !mem_req, "R1", "status during reset", int'(status), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(status == 8'h00 && !mem_req, "R1", "status after reset", int'(status), 0);

    // R3/R4: source narrower and shorter, non-unit pitches
    set_desc(1, 32'h1_0000, 2, 3, 1, 4, 3);
    set_desc(2, 32'h4_0010, 1, 5, 2, 6, 5);
    start_blit(1, 2, 0);
    finish_blit("copy src-limited");

    // R4: destination limits width, source limits height
    set_desc(3, 32'h1_0123, 3, 17, 0, 7, 2);
    set_desc(4, 32'h4_0200, 2, 1, 3, 2, 6);
    start_blit(3, 4, 0);
    finish_blit("copy mixed extent");

    // R6: masked copy leaves pre-filled bytes under zero sources
    set_desc(5, 32'h1_0040, 1, 0, 0, 24, 4);
    set_desc(6, 32'h4_0800, 2, 9, 1, 30, 4);
    start_blit(5, 6, 1);
    finish_blit("masked copy");

    // R4: zero height window -> no pixel traffic
    set_desc(7, 32'h4_0900, 1, 0, 0, 10, 0);
    start_blit(1, 7, 0);
    finish_blit("zero extent");

    // R8: command during a running transfer
    set_desc(8, 32'h1_0300, 2, 4, 2, 30, 6);
    set_desc(11, 32'h4_1000, 3, 8, 0, 32, 6);
    start_blit(8, 11, 0);
    repeat (4) @(negedge clk);
    cmd_valid = 1'b1; cmd_src_id = 4'd1; cmd_dst_id = 4'd2; cmd_op = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(status == 8'h05, "R8", "busy with error after dropped command", int'(status), 5);
    finish_blit("busy-reject");

    // R7: acceptance clears done and error
    start_blit(3, 4, 1);
    chk(status == 8'h01, "R7", "status right after accept", int'(status), 1);
    finish_blit("after-error");

    // R6: unsupported operation code
    rlog.delete(); wlog.delete();
    issue(1, 2, 2);
    chk(status == 8'h06, "R6", "status after op 2", int'(status), 6);
    repeat (10) @(negedge clk);
    chk(rlog.size() == 0 && wlog.size() == 0 && !mem_req, "R6", "accesses after op 2",
        rlog.size() + wlog.size(), 0);

    // random windows, both operations
    for (int n = 0; n < 8; n++) begin
      set_desc(9, 32'h1_0000 + $urandom_range(0, 255), $urandom_range(1, 3),
               $urandom_range(0, 200), $urandom_range(0, 3),
               $urandom_range(1, 40), $urandom_range(1, 4));
      set_desc(10, 32'h4_0000 + $urandom_range(0, 255), $urandom_range(1, 3),
               $urandom_range(0, 200), $urandom_range(0, 3),
               $urandom_range(1, 40), $urandom_range(1, 4));
      start_blit(9, 10, $urandom_range(0, 1));
      finish_blit("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule